// File: doc/BRIEF.md
# SD Luma/Chroma Word Packer

This block sits in the fast receive clock domain of a multi-rate serial video receiver. Standard-definition video arrives one 10-bit sample at a time on the low half of a 20-bit bus. A sparse strobe qualifies each sample, so the slow sample rate rides on the fast clock. The samples follow the interleaved order Cb, Y, Cr, Y. The block turns this stream into the 20-bit word format used by the high-definition paths: luma goes in the upper half and chroma in the lower half, one word for each chroma/luma pair.

The block finds the chroma/luma phase by watching the valid samples for a timing reference (all-ones, zero, zero, status word). The two halves of the reference are paired with each other, so the reference passes through as two words. The sample after the status word is taken as Cb. From then on, pairing runs on the sample count. When the input strobe keeps its ideal spacing, the output strobe settles to one pulse every 11 clocks.

Top module: `sd_pair_packer`

## Requirements
- R1: Bits [19:10] of `in_data` never affect any output. Only bits [9:0] of each valid sample are used.
- R2: After reset, `locked` stays low and `out_valid` is never asserted until a timing reference has been seen. Once `locked` goes high it stays high until reset.
- R3: When the valid samples 3FF, 000, 000, S arrive in that order (S is any value), the block emits the word {S, 000} and raises `locked`, both on the clock after S is captured.
- R4: Once locked, each pair is made of a leading sample and the valid sample that follows it. The leading sample goes to `out_data[9:0]` and the following sample to `out_data[19:10]`. The first leading sample after a reference status word is Cb, so the outputs alternate {Y,Cb} and {Y,Cr}.
- R5: `out_valid` is high for exactly one clock. It rises on the clock after the valid input that completes a pair is captured.
- R6: `out_data` holds its value in every cycle where `out_valid` is low.
- R7: With the ideal input strobe (high 1, low 4, high 1, low 5, repeating), consecutive `out_valid` pulses are exactly 11 clocks apart.
- R8: With irregular strobe spacing, including back-to-back samples, pairing follows the sample count alone and the output strobe follows the input timing.
- R9: A synchronous active-high `rst` clears `locked`, `out_valid`, `out_data` and the pairing phase.
- R10: A timing reference that arrives while locked on the wrong phase realigns the pairing. The status word closes a pair and the next sample leads the next pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 20 | Input bus; sample on bits [9:0] |
| in_valid | input | 1 | Qualifies one input sample per high cycle |
| out_data | output | 20 | Packed word: luma [19:10], chroma [9:0] |
| out_valid | output | 1 | One-clock strobe for a new packed word |
| locked | output | 1 | Phase established from a timing reference |

## Verification
Some rules are checked by the assertions on every cycle. These are the one-clock width of the output strobe and its link to the input strobe, the gating of output by lock, lock staying high once set, the output rising together with lock, and data holding between pulses. Other behaviours can only be shown by the bench's scenarios, where a scoreboard compares each packed word with a model: the ordering of the halves, the Cb-first phase after a reference, that the upper input bits are ignored, the 11-clock cadence under ideal spacing, pairing under irregular spacing, and realignment on a misplaced reference.

// File: rtl/sd_pack_pkg.sv
package sd_pack_pkg;
  typedef enum logic {PH_LEAD = 1'b0, PH_TRAIL = 1'b1} pair_phase_e;

  localparam int REF_WORDS = 3;
endpackage

// File: rtl/sd_trs_watch.sv
module sd_trs_watch #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_v,
  input  logic [W-1:0] smp,
  output logic         ref_hit
);
  import sd_pack_pkg::*;

  logic [W-1:0] hist [REF_WORDS];
  logic         head_ok;
  logic         zeros_ok;

  // hist[0] is the most recent valid sample
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REF_WORDS; i++) hist[i] <= '0;
    end else if (smp_v) begin
      hist[0] <= smp;
      for (int i = 1; i < REF_WORDS; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    head_ok  = (hist[REF_WORDS-1] == {W{1'b1}});
    zeros_ok = 1'b1;
    for (int i = 0; i < REF_WORDS - 1; i++)
      if (hist[i] != '0) zeros_ok = 1'b0;
  end

  assign ref_hit = smp_v && head_ok && zeros_ok;
endmodule

// File: rtl/sd_pair_core.sv
module sd_pair_core #(
  parameter int W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_v,
  input  logic [W-1:0]   smp,
  input  logic           ref_hit,
  output logic [2*W-1:0] word_q,
  output logic           word_v,
  output logic           lock_q
);
  import sd_pack_pkg::*;

  pair_phase_e  phase;
  logic [W-1:0] lead_q;
  logic         close_pair;

  assign close_pair = smp_v && (ref_hit || (lock_q && phase == PH_TRAIL));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_LEAD;
      lead_q <= '0;
      word_q <= '0;
      word_v <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      word_v <= 1'b0;
      if (close_pair) begin
        word_q <= {smp, lead_q};
        word_v <= 1'b1;
        phase  <= PH_LEAD;
      end else if (smp_v) begin
        lead_q <= smp;
        phase  <= PH_TRAIL;
      end
      if (ref_hit) lock_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sd_pair_packer.sv
module sd_pair_packer #(
  parameter int SAMPLE_W = 10,
  localparam int BUS_W = 2 * SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] in_data,
  input  logic             in_valid,
  output logic [BUS_W-1:0] out_data,
  output logic             out_valid,
  output logic             locked
);
  logic [SAMPLE_W-1:0] smp;
  logic [SAMPLE_W-1:0] unused_hi;
  logic                ref_hit;

  assign smp       = in_data[SAMPLE_W-1:0];
  assign unused_hi = in_data[BUS_W-1:SAMPLE_W];

  sd_trs_watch #(.W(SAMPLE_W)) watch_i (
    .clk(clk), .rst(rst), .smp_v(in_valid), .smp(smp), .ref_hit(ref_hit)
  );

  sd_pair_core #(.W(SAMPLE_W)) core_i (
    .clk(clk), .rst(rst), .smp_v(in_valid), .smp(smp), .ref_hit(ref_hit),
    .word_q(out_data), .word_v(out_valid), .lock_q(locked)
  );
endmodule

// File: rtl/sd_pair_packer_chk.sv
module sd_pair_packer_chk #(
  parameter int BUS_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [BUS_W-1:0] out_data,
  input logic             out_valid,
  input logic             locked
);
  logic armed;
  always_ff @(posedge clk) armed <= rst ? 1'b0 : 1'b1;

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_after_input_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && out_valid) |-> $past(in_valid));

  p_gated_by_lock_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> locked);

  p_lock_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && locked) |=> locked);

  p_lock_with_word_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(locked)) |-> out_valid);

  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && !out_valid) |-> $stable(out_data));
endmodule

bind sd_pair_packer sd_pair_packer_chk #(.BUS_W(BUS_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_data(out_data), .out_valid(out_valid), .locked(locked)
);

// File: tb/sd_pair_packer_tb_top.sv
module sd_pair_packer_tb_top;
  localparam int W = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2*W-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic [2*W-1:0] out_data;
  logic          out_valid;
  logic          locked;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  sd_pair_packer #(.SAMPLE_W(W)) dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid), .locked(locked)
  );

  // reference model state (from the requirements)
  logic [W-1:0] m_hist [3];
  logic [W-1:0] m_lead;
  logic         m_trail;
  logic         m_lock;
  logic [2*W-1:0] exp_q [$];
  string          tag_q [$];

  // cadence tracking
  logic ideal_mode = 1'b0;
  int   cyc = 0;
  int   last_pulse = -1;
  logic last_iv = 1'b0;
  logic [2*W-1:0] last_out = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) m_hist[i] = '0;
    m_lead = '0; m_trail = 1'b0; m_lock = 1'b0;
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic model_step(input logic [W-1:0] w);
    logic hit;
    hit = (m_hist[2] == {W{1'b1}}) && (m_hist[1] == '0) && (m_hist[0] == '0);
    if (hit || (m_lock && m_trail)) begin
      exp_q.push_back({w, m_lead});
      tag_q.push_back(hit ? "R3" : "R4");
      m_trail = 1'b0;
    end else begin
      m_lead = w; m_trail = 1'b1;
    end
    if (hit) m_lock = 1'b1;
    m_hist[2] = m_hist[1]; m_hist[1] = m_hist[0]; m_hist[0] = w;
  endtask

  task automatic send(input logic [W-1:0] w, input int gap);
    @(posedge clk); #2;
    in_data  = {W'($urandom), w};   // R1: junk on the upper half
    in_valid = 1'b1;
    model_step(w);
    if (gap > 0) begin
      @(posedge clk); #2;
      in_valid = 1'b0;
      in_data  = 2*W'($urandom);
      repeat (gap - 1) @(posedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(posedge clk); #2;
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic send_ref(input logic [W-1:0] s, input int gap);
    send({W{1'b1}}, gap); send('0, gap); send('0, gap); send(s, gap);
  endtask

  task automatic send_line(input int n, input int base, input bit ideal);
    for (int i = 0; i < n; i++)
      send(W'(base + i * 7), ideal ? ((i % 2 == 0) ? 4 : 5) : (i % 4) * 3 % 7);
  endtask

  always @(posedge clk) begin
    last_iv <= in_valid;
    cyc     <= cyc + 1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        check(last_iv, "R5", "pulse without preceding input strobe", 32'(last_iv), 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected output word", 32'(out_data), 0);
        end else begin
          logic [2*W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, "packed word", 32'(out_data), 32'(e));
        end
        if (ideal_mode && last_pulse >= 0)
          check(cyc - last_pulse == 11, "R7", "pulse spacing",
                32'(cyc - last_pulse), 11);
        last_pulse = ideal_mode ? cyc : -1;
        last_out   = out_data;
      end else begin
        if (out_data != last_out)
          check(1'b0, "R6", "data changed without strobe", 32'(out_data), 32'(last_out));
      end
    end else begin
      last_out   = '0;
      last_pulse = -1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 0 && locked == 0 && out_data == 0, "R9", "reset state",
          {out_valid, locked, 20'(out_data)}, 0);
    rst = 1'b0;

    // R2: no lock, no output before a reference
    for (int i = 0; i < 12; i++) send(W'(10'h040 + i), 5);
    idle(3);
    check(locked == 0, "R2", "locked before reference", 32'(locked), 0);
    check(exp_q.size() == 0, "R2", "model produced words pre-lock", exp_q.size(), 0);

    // R3: reference then ideal line (R4, R7, R1)
    ideal_mode = 1'b1;
    send({W{1'b1}}, 4); send('0, 5); send('0, 4); send(10'h274, 5);
    #1;
    check(locked == 1, "R3", "lock after reference", 32'(locked), 1);
    send_line(40, 10'h080, 1'b1);
    idle(12);
    ideal_mode = 1'b0;
    check(exp_q.size() == 0, "R4", "pending words after ideal line", exp_q.size(), 0);

    // R8: irregular spacing incl. back-to-back
    send_line(30, 10'h1A0, 1'b0);
    send(10'h111, 0); send(10'h222, 0); send(10'h333, 0); send(10'h044, 2);
    idle(4);
    check(exp_q.size() == 0, "R8", "pending words after irregular line", exp_q.size(), 0);

    // R10: misalign by one sample, then reference realigns
    send(10'h155, 5);
    send_ref(10'h2D8, 5);
    send_line(10, 10'h300, 1'b1);
    idle(12);
    check(exp_q.size() == 0, "R10", "pending words after realign", exp_q.size(), 0);
    check(locked == 1, "R2", "lock stays high", 32'(locked), 1);

    // R1: reference words hidden only in the upper half must not lock
    @(posedge clk); #2;
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
    model_clear();
    #1;
    check(locked == 0 && out_valid == 0, "R9", "state after mid-stream reset",
          {locked, out_valid}, 0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      in_data  = {(i == 0 || i == 3) ? {W{1'b1}} : {W{1'b0}}, W'(10'h0C0 + i)};
      in_valid = 1'b1;
      model_step(W'(10'h0C0 + i));
      @(posedge clk); #2;
      in_valid = 1'b0;
      repeat (3) @(posedge clk);
    end
    idle(3);
    check(locked == 0, "R1", "upper bits caused lock", 32'(locked), 0);

    // R9: after reset a fresh reference locks again with Cb first
    send_ref(10'h200, 3);
    send_line(8, 10'h010, 1'b1);
    idle(12);
    check(locked == 1, "R9", "relock after reset", 32'(locked), 1);
    check(exp_q.size() == 0, "R4", "pending words at end", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule